// File: doc/BRIEF.md
# External Interrupt Trigger Controller

This block watches 24 external interrupt pins and turns their activity into six interrupt requests for a parent interrupt controller. Every pin is first brought into the clock domain through a two-flop synchroniser. A programmable detector then decides, line by line, whether an event has happened: the pin sitting low, sitting high, or a falling, rising or any edge. Each event sets a sticky pending bit. A mask register decides which pending bits reach the parent outputs.

Lines 0 to 3 each own a parent output. Lines 4 to 7 share one output, and lines 8 to 23 share another. A handler that takes a shared output reads the pending register and removes the masked bits. It then keeps only the bits in that output's range and services them from the lowest bit upward, writing a one to each pending bit to clear it.

Software uses a plain register port with an address, a write strobe, write data and read data. There is no valid/ready pair, because the port carries control and status and not a data stream. A write completes on the clock edge where `we_i` is high. Read data is combinational from `addr_i` with zero wait states, so the port never applies back-pressure.

Top module: `xirq_trigger_ctrl`

## Requirements
- R1: While reset is held, every configuration word reads 0, the mask register reads 0x00FFFFFF, the pending register reads 0 and all six outputs are low.
- R2: The synchroniser and the detector together give a fixed latency. A pin change made between clock edges shows in the pending register after the third following rising edge, and not after the second.
- R3: Line i has a 4-bit trigger field in the word at address 0x88 + 4*(i/8), at bit 4*(i%8). The low three bits select the trigger: 0 means low level, 1 high level, 2 falling edge, 4 rising edge and 6 both edges.
- R4: Codes 3, 5 and 7 act as both edges. Bit 3 of each field reads back as written and has no effect on detection.
- R5: The pending register is at 0xA8. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R6: In a level mode, the pending bit is set again on every clock while the level holds, so clearing it during the level has no lasting effect.
- R7: If a clear and a new event hit the same pending bit on the same clock edge, the bit stays set.
- R8: The mask register is at 0xA4 and can be read and written. Bit i set to 1 blocks line i and 0 passes it. Only the low 24 bits are stored, and the upper bits read 0.
- R9: Outputs 0 to 3 each equal their own line's pending bit ANDed with the inverse of its mask bit.
- R10: Output 4 is the OR of the unmasked pending bits of lines 4 to 7. Output 5 is the OR of the unmasked pending bits of lines 8 to 23.
- R11: A pending bit is set by its event whatever its mask bit is. With the reset configuration of low level on all lines, pins held low make every pending bit set, while all outputs stay low.
- R12: An address that matches no register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 24 | External interrupt pins, asynchronous to the clock |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from addr_i |
| irq_o | output | 6 | Parent interrupt requests: 0 to 3 direct, 4 for lines 4 to 7, 5 for lines 8 to 23 |

## Verification
The detector is driven from a table of short pin waveforms. Each trigger code gets a waveform that should set the pending bit and one that should not, for example a falling step under a rising-edge code or a pin that never leaves the inactive level. The whole pending vector is checked each time, which separates a correct line from cross-talk into its neighbours. The expected output is checked too, which separates the direct outputs from the two shared ones. Directed sequences then aim at timing: a pin step sampled one clock before and at the expected latency, a clear issued on the very edge where an edge event lands, and a clear one cycle later. Other directed sequences clear a held level, write all-zero data to the pending register, and set two bits in a shared group and clear them one at a time.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int unsigned FIELD_W  = 4;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned CFG_BASE = 32'h88;
  localparam int unsigned MASK_OFS = 32'hA4;
  localparam int unsigned PEND_OFS = 32'hA8;

  typedef enum logic [CODE_W-1:0] {
    TRIG_LEVEL_LO = 3'd0,
    TRIG_LEVEL_HI = 3'd1,
    TRIG_EDGE_DN  = 3'd2,
    TRIG_EDGE_UP  = 3'd4,
    TRIG_EDGE_ANY = 3'd6
  } trig_code_e;

  typedef struct packed {
    logic is_level;
    logic level_hi;
    logic on_rise;
    logic on_fall;
  } trig_sel_t;

  // Unlisted codes 3, 5 and 7 fall through to both edges.
  function automatic trig_sel_t decode_trig(input logic [CODE_W-1:0] code);
    trig_sel_t sel;
    case (code)
      TRIG_LEVEL_LO: sel = '{is_level: 1'b1, level_hi: 1'b0, on_rise: 1'b0, on_fall: 1'b0};
      TRIG_LEVEL_HI: sel = '{is_level: 1'b1, level_hi: 1'b1, on_rise: 1'b0, on_fall: 1'b0};
      TRIG_EDGE_DN:  sel = '{is_level: 1'b0, level_hi: 1'b0, on_rise: 1'b0, on_fall: 1'b1};
      TRIG_EDGE_UP:  sel = '{is_level: 1'b0, level_hi: 1'b0, on_rise: 1'b1, on_fall: 1'b0};
      default:       sel = '{is_level: 1'b0, level_hi: 1'b0, on_rise: 1'b1, on_fall: 1'b1};
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned LINES  = 24,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] pin_i,
  output logic [LINES-1:0] cur_o,
  output logic [LINES-1:0] prev_o
);

  logic [LINES-1:0] stage_q [STAGES];
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign cur_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int unsigned LINES = 24
) (
  input  logic [LINES-1:0]         cur_i,
  input  logic [LINES-1:0]         prev_i,
  input  logic [LINES*FIELD_W-1:0] cfg_i,
  output logic [LINES-1:0]         evt_o
);

  localparam int unsigned SPARE_W = FIELD_W - CODE_W;

  logic [LINES*SPARE_W-1:0] unused_spare;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    trig_sel_t sel;
    logic      rise;
    logic      fall;

    assign sel  = decode_trig(cfg_i[i*FIELD_W +: CODE_W]);
    assign rise = cur_i[i] & ~prev_i[i];
    assign fall = ~cur_i[i] & prev_i[i];
    assign evt_o[i] = sel.is_level ? (cur_i[i] == sel.level_hi)
                                   : ((sel.on_rise & rise) | (sel.on_fall & fall));
    assign unused_spare[i*SPARE_W +: SPARE_W] = cfg_i[i*FIELD_W + CODE_W +: SPARE_W];
  end

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned LINES  = 24,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [LINES-1:0]         evt_i,
  output logic [LINES*FIELD_W-1:0] cfg_o,
  output logic [LINES-1:0]         mask_o,
  output logic [LINES-1:0]         pend_o,
  output logic [DATA_W-1:0]        rdata_o
);

  localparam int unsigned PER_WORD = DATA_W / FIELD_W;
  localparam int unsigned CFG_REGS = (LINES + PER_WORD - 1) / PER_WORD;
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(MASK_OFS);
  localparam logic [ADDR_W-1:0] PEND_ADDR = ADDR_W'(PEND_OFS);

  logic [DATA_W-1:0]          cfg_q [CFG_REGS];
  logic [CFG_REGS*DATA_W-1:0] cfg_flat;
  logic [LINES-1:0]           mask_q;
  logic [LINES-1:0]           pend_q;
  logic [LINES-1:0]           clr_vec;
  logic [CFG_REGS-1:0]        cfg_hit;

  for (genvar r = 0; r < CFG_REGS; r++) begin : g_word
    assign cfg_hit[r] = (addr_i == ADDR_W'(CFG_BASE + 4*r));
    assign cfg_flat[r*DATA_W +: DATA_W] = cfg_q[r];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < CFG_REGS; r++) cfg_q[r] <= '0;
    end else if (we_i) begin
      for (int r = 0; r < CFG_REGS; r++)
        if (cfg_hit[r]) cfg_q[r] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_q <= '1;
    else if (we_i && addr_i == MASK_ADDR) mask_q <= wdata_i[LINES-1:0];
  end

  // A fresh event overrides a simultaneous write-one-to-clear.
  assign clr_vec = (we_i && addr_i == PEND_ADDR) ? wdata_i[LINES-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_vec) | evt_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < CFG_REGS; r++)
      if (cfg_hit[r]) rdata_o = cfg_q[r];
    if (addr_i == MASK_ADDR) rdata_o = DATA_W'(mask_q);
    if (addr_i == PEND_ADDR) rdata_o = DATA_W'(pend_q);
  end

  assign cfg_o  = cfg_flat[LINES*FIELD_W-1:0];
  assign mask_o = mask_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/xirq_group.sv
module xirq_group #(
  parameter int unsigned LINES    = 24,
  parameter int unsigned DIRECT   = 4,
  parameter int unsigned MID_LAST = 7,
  localparam int unsigned OUTS    = DIRECT + 2
) (
  input  logic [LINES-1:0] pend_i,
  input  logic [LINES-1:0] mask_i,
  output logic [OUTS-1:0]  irq_o
);

  logic [LINES-1:0] live;

  assign live = pend_i & ~mask_i;

  for (genvar k = 0; k < DIRECT; k++) begin : g_direct
    assign irq_o[k] = live[k];
  end

  assign irq_o[DIRECT]   = |live[MID_LAST:DIRECT];
  assign irq_o[DIRECT+1] = |live[LINES-1:MID_LAST+1];

endmodule

// File: rtl/xirq_trigger_ctrl.sv
module xirq_trigger_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned LINES       = 24,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIRECT      = 4,
  parameter int unsigned MID_LAST    = 7,
  localparam int unsigned OUTS       = DIRECT + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINES-1:0]  pin_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [OUTS-1:0]   irq_o
);

  logic [LINES-1:0]         cur_w;
  logic [LINES-1:0]         prev_w;
  logic [LINES-1:0]         evt_w;
  logic [LINES*FIELD_W-1:0] cfg_w;
  logic [LINES-1:0]         mask_w;
  logic [LINES-1:0]         pend_w;

  xirq_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .cur_o (cur_w),
    .prev_o(prev_w)
  );

  xirq_detect #(.LINES(LINES)) u_detect (
    .cur_i (cur_w),
    .prev_i(prev_w),
    .cfg_i (cfg_w),
    .evt_o (evt_w)
  );

  xirq_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .evt_i  (evt_w),
    .cfg_o  (cfg_w),
    .mask_o (mask_w),
    .pend_o (pend_w),
    .rdata_o(rdata_o)
  );

  xirq_group #(.LINES(LINES), .DIRECT(DIRECT), .MID_LAST(MID_LAST)) u_group (
    .pend_i(pend_w),
    .mask_i(mask_w),
    .irq_o (irq_o)
  );

endmodule

// File: rtl/xirq_trigger_ctrl_chk.sv
module xirq_trigger_ctrl_chk
  import xirq_pkg::*;
#(
  parameter int unsigned LINES    = 24,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DIRECT   = 4,
  parameter int unsigned MID_LAST = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [LINES-1:0]  evt,
  input logic [LINES-1:0]  pend,
  input logic [LINES-1:0]  mask,
  input logic [DIRECT+1:0] irq
);

  logic             pend_wr;
  logic             mask_wr;
  logic [LINES-1:0] wr_ones;

  assign pend_wr = we_i && (addr_i == ADDR_W'(PEND_OFS));
  assign mask_wr = we_i && (addr_i == ADDR_W'(MASK_OFS));
  assign wr_ones = pend_wr ? wdata_i[LINES-1:0] : '0;

  AST_DIRECT_OUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq[DIRECT-1:0] == (pend[DIRECT-1:0] & ~mask[DIRECT-1:0])); // R9

  AST_MID_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq[DIRECT] == |(pend[MID_LAST:DIRECT] & ~mask[MID_LAST:DIRECT])); // R10

  AST_WIDE_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq[DIRECT+1] == |(pend[LINES-1:MID_LAST+1] & ~mask[LINES-1:MID_LAST+1])); // R10

  AST_PEND_FALLS_ON_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend) & ~pend & ~$past(wr_ones)) == '0)); // R5

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((pend & $past(evt)) == $past(evt))); // R7

  AST_MASK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr |=> $stable(mask)); // R8

endmodule

bind xirq_trigger_ctrl xirq_trigger_ctrl_chk #(
  .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIRECT(DIRECT), .MID_LAST(MID_LAST)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .evt    (evt_w),
  .pend   (pend_w),
  .mask   (mask_w),
  .irq    (irq_o)
);

// File: tb/xirq_trigger_ctrl_tb_top.sv
module xirq_trigger_ctrl_tb_top;

  localparam logic [7:0] A_CFG0 = 8'h88;
  localparam logic [7:0] A_MASK = 8'hA4;
  localparam logic [7:0] A_PEND = 8'hA8;
  localparam logic [31:0] ALL24 = 32'h00FF_FFFF;

  // entry: line[13:9] code[8:5] start[4] seq[3:1] (bit 3 applied first) expect[0]
  localparam int NVEC = 14;
  localparam logic [13:0] VECS [NVEC] = '{
    {5'd5,  4'd4,  1'b0, 3'b111, 1'b1},  // R3 rise seen
    {5'd5,  4'd4,  1'b1, 3'b000, 1'b0},  // R3 fall ignored by rise
    {5'd9,  4'd2,  1'b1, 3'b000, 1'b1},  // R3 fall seen
    {5'd9,  4'd2,  1'b0, 3'b111, 1'b0},  // R3 rise ignored by fall
    {5'd17, 4'd6,  1'b0, 3'b111, 1'b1},  // R3 both, rising
    {5'd17, 4'd6,  1'b1, 3'b000, 1'b1},  // R3 both, falling
    {5'd2,  4'd1,  1'b0, 3'b000, 1'b0},  // R3 high level never reached
    {5'd2,  4'd1,  1'b0, 3'b010, 1'b1},  // R3 high level pulse
    {5'd23, 4'd0,  1'b1, 3'b111, 1'b0},  // R3 low level never reached
    {5'd23, 4'd0,  1'b1, 3'b101, 1'b1},  // R3 low level pulse
    {5'd12, 4'd3,  1'b0, 3'b111, 1'b1},  // R4 code 3 rise
    {5'd12, 4'd5,  1'b1, 3'b000, 1'b1},  // R4 code 5 fall
    {5'd0,  4'd14, 1'b0, 3'b111, 1'b1},  // R4 bit 3 ignored
    {5'd6,  4'd7,  1'b0, 3'b100, 1'b1}   // R4 code 7 pulse
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow [3];

  always #10 clk = ~clk;

  xirq_trigger_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic set_code(input int line, input logic [3:0] code);
    shadow[line/8][4*(line%8) +: 4] = code;
    wr(A_CFG0 + 8'(4*(line/8)), shadow[line/8]);
  endtask

  function automatic logic [5:0] grp_bit(input int line);
    if (line < 4) return 6'(1 << line);
    if (line < 8) return 6'b01_0000;
    return 6'b10_0000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wait_n(2);
    // R1 reset state, sampled while reset is held
    rd(A_CFG0, v);        chk("R1 cfg word 0", v, 32'h0);
    rd(A_CFG0 + 8'd8, v); chk("R1 cfg word 2", v, 32'h0);
    rd(A_MASK, v);        chk("R1 mask", v, ALL24);
    rd(A_PEND, v);        chk("R1 pending", v, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R11 default low level with pins low sets all pending, masked outputs stay low
    wait_n(5);
    rd(A_PEND, v); chk("R11 pending all set", v, ALL24);
    chk("R11 irq masked", 32'(irq), 32'h0);

    for (int r = 0; r < 3; r++) begin
      shadow[r] = 32'h4444_4444;
      wr(A_CFG0 + 8'(4*r), shadow[r]);
    end
    wait_n(4);
    wr(A_PEND, ALL24);
    rd(A_PEND, v); chk("R5 clear all", v, 32'h0);

    // table walk
    for (int e = 0; e < NVEC; e++) begin
      int          ln;
      logic [3:0]  code;
      logic [2:0]  seq;
      logic        hit;
      ln   = int'(VECS[e][13:9]);
      code = VECS[e][8:5];
      seq  = VECS[e][3:1];
      hit  = VECS[e][0];
      wr(A_MASK, ALL24 & ~(32'h1 << ln));
      set_code(ln, code);
      pins[ln] = VECS[e][4];
      wait_n(6);
      wr(A_PEND, ALL24);
      for (int s = 2; s >= 0; s--) begin
        pins[ln] = seq[s];
        wait_n(5);
      end
      rd(A_PEND, v);
      chk($sformatf("R3/R4 vec %0d pending", e), v, 32'(hit) << ln);
      chk($sformatf("R9/R10 vec %0d irq", e), 32'(irq), hit ? 32'(grp_bit(ln)) : 32'h0);
      set_code(ln, 4'd4);
      pins[ln] = 1'b0;
      wait_n(6);
      wr(A_PEND, ALL24);
    end
    wr(A_MASK, ALL24);

    // R2 latency: set after third rising edge, not before
    pins[20] = 1'b1;
    wait_n(2);
    rd(A_PEND, v); chk("R2 not yet after two edges", v & (32'h1 << 20), 32'h0);
    wait_n(1);
    rd(A_PEND, v); chk("R2 set after three edges", v & (32'h1 << 20), 32'h1 << 20);

    // R5 zeros leave pending, ones clear only their bits
    pins[3] = 1'b1;
    wait_n(5);
    wr(A_PEND, 32'h0);
    rd(A_PEND, v); chk("R5 zero write", v, (32'h1 << 20) | 32'h8);
    wr(A_PEND, 32'h8);
    rd(A_PEND, v); chk("R5 single clear", v, 32'h1 << 20);
    pins[3] = 1'b0; pins[20] = 1'b0;
    wait_n(5);
    wr(A_PEND, ALL24);

    // R6 level held: clear does not stick
    set_code(1, 4'd1);
    pins[1] = 1'b1;
    wait_n(5);
    wr(A_PEND, 32'h2);
    rd(A_PEND, v); chk("R6 level re-sets", v, 32'h2);
    pins[1] = 1'b0;
    wait_n(5);
    wr(A_PEND, 32'h2);
    rd(A_PEND, v); chk("R6 clear after level drops", v, 32'h0);
    set_code(1, 4'd4);

    // R7 clear on the edge where the event lands
    pins[10] = 1'b1;
    wait_n(2);
    wr(A_PEND, 32'h1 << 10);
    rd(A_PEND, v); chk("R7 event wins over clear", v, 32'h1 << 10);
    pins[10] = 1'b0;
    wait_n(5);
    wr(A_PEND, ALL24);
    pins[10] = 1'b1;
    wait_n(3);
    wr(A_PEND, 32'h1 << 10);
    rd(A_PEND, v); chk("R7 clear one cycle later", v, 32'h0);
    pins[10] = 1'b0;
    wait_n(5);

    // R8 mask width, R12 unmapped address
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, v); chk("R8 mask upper bits", v, ALL24);
    rd(8'h00, v);  chk("R12 unmapped read", v, 32'h0);

    // R4 bit 3 read back
    wr(A_CFG0 + 8'd4, 32'hCCCC_CCCC);
    rd(A_CFG0 + 8'd4, v); chk("R4 spare bit readback", v, 32'hCCCC_CCCC);
    wr(A_CFG0 + 8'd4, 32'h4444_4444);
    wait_n(4);
    wr(A_PEND, ALL24);

    // R10 shared group, R9 direct pair, R8 masking
    pins[9] = 1'b1; pins[15] = 1'b1; pins[1] = 1'b1; pins[3] = 1'b1;
    wait_n(5);
    chk("R8 masked outputs low", 32'(irq), 32'h0);
    wr(A_MASK, 32'h0);
    chk("R9/R10 direct and wide", 32'(irq), 32'h2A);
    wr(A_PEND, (32'h1 << 9) | 32'h2);
    chk("R10 wide still set by other line", 32'(irq), 32'h28);
    wr(A_PEND, 32'h1 << 15);
    chk("R10 wide cleared", 32'(irq), 32'h08);
    pins[5] = 1'b1;
    wait_n(5);
    chk("R10 mid group", 32'(irq), 32'h18);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule